// File: doc/BRIEF.md
# Delegating Interrupt Arbiter

This block keeps the machine-level interrupt pending, enable and delegation registers of one hart, and decides from them, cycle by cycle, whether the hart should take an interrupt and which one. Interrupt sources come from two places. Hardware request lines feed their pending bits directly. Software sets bits through a control-register port or through a one-byte memory-mapped software-interrupt register.

Every pending-and-enabled bit is a candidate. Candidates that are not delegated are qualified against the machine privilege rule. Delegated candidates are qualified against the supervisor privilege rule. The two qualified groups are merged, and the lowest-numbered bit wins. The supervisor views of pending and enable are aliases of the machine registers, masked by the delegation register.

The control-register port is a plain write-enable port with a combinational read, because it lives inside the hart's register-access path. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Bit positions are fixed:

| Bit | Meaning |
|-----|---------|
| 1 | supervisor software |
| 3 | machine software |
| 5 | supervisor timer |
| 7 | machine timer |
| 9 | supervisor external |
| 11 | machine external |
| 12 | coprocessor |

Privilege codes are U=0, S=1 and M=3. They are compared numerically.

Top module: `irq_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the pending, enable and delegation registers read 0, and `take` and `cause` are 0.
- R2: A write to the delegation register (`csr_sel`=2) keeps only bits 1, 5, 9 and 12. All other bits read back 0.
- R3: A write to the machine pending register (`csr_sel`=0) changes only bits 1 and 5. Bits 7, 11, 9 and 12 copy `irq_mtimer`, `irq_mext`, `irq_sext` and `irq_cop` one clock after the line is sampled, and software cannot write them.
- R4: A write to the machine enable register (`csr_sel`=1) keeps only bits 1, 3, 5, 7, 9, 11 and 12.
- R5: The supervisor pending view (`csr_sel`=3) and enable view (`csr_sel`=4) read as the machine register ANDed with the delegation register. A write through either view changes only the delegated positions that the machine register would accept. Any other `csr_sel` value reads 0.
- R6: A store with `mm_off`=0 sets bit 3 of the pending register to `mm_byte[0]` and raises `mm_ack` in the same cycle. A store to any other offset leaves `mm_ack` at 0 and changes nothing.
- R7: A non-delegated candidate is eligible only when `priv` is below 3, or `priv` is 3 and `mie_glb` is 1.
- R8: A delegated candidate is eligible only when `priv` is below 1, or `priv` is 1 and `sie_glb` is 1.
- R9: The eligible groups are merged. `take` is 1 and `cause` is the index of the lowest set bit. Both are combinational from the registers and the privilege inputs.
- R10: When no bit is eligible, `take` and `cause` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| priv | input | 2 | current privilege (U=0, S=1, M=3) |
| mie_glb | input | 1 | machine global interrupt enable |
| sie_glb | input | 1 | supervisor global interrupt enable |
| irq_mtimer | input | 1 | machine timer request line |
| irq_mext | input | 1 | machine external request line |
| irq_sext | input | 1 | supervisor external request line |
| irq_cop | input | 1 | coprocessor request line |
| csr_we | input | 1 | register write strobe |
| csr_sel | input | 3 | register select (0 mpend, 1 men, 2 deleg, 3 spend, 4 sen) |
| csr_wdata | input | XLEN | register write data |
| csr_rdata | output | XLEN | register read data, combinational |
| mm_we | input | 1 | memory-mapped store strobe |
| mm_off | input | OFFW | memory-mapped store offset |
| mm_byte | input | 8 | memory-mapped store data byte |
| mm_ack | output | 1 | store accepted |
| take | output | 1 | an interrupt should be taken |
| cause | output | CW | index of the interrupt to take |

## Verification
The bench goes after cases where both privilege rules meet:
- **Interrupt delegated while running at M.** This must lose. A design that qualified every candidate by the machine rule would take it.
- **Non-delegated bit while running at S with both globals off.** This must win. A design that read the global enable at the wrong level would stay silent.
- **Several bits eligible at once.** A priority encoder scanning from the top would report 7 where 1 is expected.

Writes through the supervisor views with all ones are checked to leave non-delegated bits untouched, so a view that wrote the full mask shows up as a changed machine register. Memory-mapped stores to nonzero offsets are checked for both a missing acknowledge and an unchanged software bit.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned BIT_SSW = 1;
  localparam int unsigned BIT_MSW = 3;
  localparam int unsigned BIT_STM = 5;
  localparam int unsigned BIT_MTM = 7;
  localparam int unsigned BIT_SEX = 9;
  localparam int unsigned BIT_MEX = 11;
  localparam int unsigned BIT_COP = 12;
  localparam int unsigned MIN_IRQS = 13;

  localparam logic [31:0] MASK_DELEG = (32'd1 << BIT_SSW) | (32'd1 << BIT_STM) |
                                       (32'd1 << BIT_SEX) | (32'd1 << BIT_COP);
  localparam logic [31:0] MASK_SWPEND = (32'd1 << BIT_SSW) | (32'd1 << BIT_STM);
  localparam logic [31:0] MASK_HWPEND = (32'd1 << BIT_MTM) | (32'd1 << BIT_MEX) |
                                        (32'd1 << BIT_SEX) | (32'd1 << BIT_COP);
  localparam logic [31:0] MASK_IMPL = MASK_DELEG | (32'd1 << BIT_MSW) |
                                      (32'd1 << BIT_MTM) | (32'd1 << BIT_MEX);

  typedef enum logic [2:0] {
    SEL_MPEND = 3'd0,
    SEL_MEN   = 3'd1,
    SEL_DELEG = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_SEN   = 3'd4
  } csr_sel_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_mtimer,
  input  logic            irq_mext,
  input  logic            irq_sext,
  input  logic            irq_cop,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            mm_we,
  input  logic [OFFW-1:0] mm_off,
  input  logic [7:0]      mm_byte,
  output logic            mm_ack,
  output logic [NIRQ-1:0] pend_q,
  output logic [NIRQ-1:0] en_q,
  output logic [NIRQ-1:0] deleg_q
);
  localparam logic [NIRQ-1:0] DMASK = NIRQ'(MASK_DELEG);
  localparam logic [NIRQ-1:0] SWMASK = NIRQ'(MASK_SWPEND);
  localparam logic [NIRQ-1:0] HWMASK = NIRQ'(MASK_HWPEND);
  localparam logic [NIRQ-1:0] IMASK = NIRQ'(MASK_IMPL);

  logic [NIRQ-1:0] wval, hw_vec, pend_wm, en_wm, pend_d, en_d, deleg_d;
  csr_sel_e sel;

  assign sel  = csr_sel_e'(csr_sel);
  assign wval = csr_wdata[NIRQ-1:0];
  assign mm_ack = mm_we && (mm_off == '0);

  always_comb begin
    hw_vec = '0;
    hw_vec[BIT_MTM] = irq_mtimer;
    hw_vec[BIT_MEX] = irq_mext;
    hw_vec[BIT_SEX] = irq_sext;
    hw_vec[BIT_COP] = irq_cop;
  end

  always_comb begin
    pend_wm = '0;
    en_wm   = '0;
    if (csr_we) begin
      unique case (sel)
        SEL_MPEND: pend_wm = SWMASK;
        SEL_SPEND: pend_wm = SWMASK & deleg_q;
        SEL_MEN:   en_wm   = IMASK;
        SEL_SEN:   en_wm   = IMASK & deleg_q;
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_d = (pend_q & ~HWMASK & ~pend_wm) | (wval & pend_wm) | hw_vec;
    if (mm_ack) pend_d[BIT_MSW] = mm_byte[0];
    en_d    = (en_q & ~en_wm) | (wval & en_wm);
    deleg_d = (csr_we && sel == SEL_DELEG) ? (wval & DMASK) : deleg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      deleg_q <= '0;
    end else begin
      pend_q  <= pend_d;
      en_q    <= en_d;
      deleg_q <= deleg_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MPEND: csr_rdata = XLEN'(pend_q);
      SEL_MEN:   csr_rdata = XLEN'(en_q);
      SEL_DELEG: csr_rdata = XLEN'(deleg_q);
      SEL_SPEND: csr_rdata = XLEN'(pend_q & deleg_q);
      SEL_SEN:   csr_rdata = XLEN'(en_q & deleg_q);
      default:   csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ = 16
) (
  input  logic [1:0]      priv,
  input  logic            mie_glb,
  input  logic            sie_glb,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic [NIRQ-1:0] deleg,
  output logic [NIRQ-1:0] elig
);
  logic [NIRQ-1:0] cand;
  logic m_ok, s_ok;

  assign cand = pend & en;
  assign m_ok = (priv < PRIV_M) || (priv == PRIV_M && mie_glb);
  assign s_ok = (priv < PRIV_S) || (priv == PRIV_S && sie_glb);
  assign elig = (cand & ~deleg & {NIRQ{m_ok}}) | (cand & deleg & {NIRQ{s_ok}});
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned CW = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] req,
  output logic            found,
  output logic [CW-1:0]   idx
);
  logic [NIRQ:0]   below;
  logic [NIRQ-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < NIRQ; i++) begin : g_chain
    assign first[i]   = req[i] & ~below[i];
    assign below[i+1] = below[i] | req[i];
  end

  assign found = below[NIRQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NIRQ; i++)
      if (first[i]) idx = idx | CW'(i);
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 4,
  localparam int unsigned CW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv,
  input  logic            mie_glb,
  input  logic            sie_glb,
  input  logic            irq_mtimer,
  input  logic            irq_mext,
  input  logic            irq_sext,
  input  logic            irq_cop,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            mm_we,
  input  logic [OFFW-1:0] mm_off,
  input  logic [7:0]      mm_byte,
  output logic            mm_ack,
  output logic            take,
  output logic [CW-1:0]   cause
);
  if (NIRQ < MIN_IRQS || XLEN < NIRQ) begin : g_bad_cfg
    initial $error("irq_arb: NIRQ must be at least 13 and no wider than XLEN");
  end

  logic [NIRQ-1:0] pend_w, en_w, deleg_w, elig_w;
  logic            found_w;
  logic [CW-1:0]   idx_w;

  irq_csr_regs #(.NIRQ(NIRQ), .XLEN(XLEN), .OFFW(OFFW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .irq_mtimer(irq_mtimer), .irq_mext(irq_mext), .irq_sext(irq_sext), .irq_cop(irq_cop),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mm_we(mm_we), .mm_off(mm_off), .mm_byte(mm_byte), .mm_ack(mm_ack),
    .pend_q(pend_w), .en_q(en_w), .deleg_q(deleg_w)
  );

  irq_qualify #(.NIRQ(NIRQ)) u_qual (
    .priv(priv), .mie_glb(mie_glb), .sie_glb(sie_glb),
    .pend(pend_w), .en(en_w), .deleg(deleg_w), .elig(elig_w)
  );

  irq_lowest_pick #(.NIRQ(NIRQ), .CW(CW)) u_pick (
    .req(elig_w), .found(found_w), .idx(idx_w)
  );

  assign take  = found_w;
  assign cause = found_w ? idx_w : '0;
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 4,
  parameter int unsigned CW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      priv,
  input logic            mie_glb,
  input logic            sie_glb,
  input logic            irq_mtimer,
  input logic [2:0]      csr_sel,
  input logic [XLEN-1:0] csr_rdata,
  input logic            mm_we,
  input logic [OFFW-1:0] mm_off,
  input logic [7:0]      mm_byte,
  input logic            mm_ack,
  input logic            take,
  input logic [CW-1:0]   cause,
  input logic [NIRQ-1:0] pend,
  input logic [NIRQ-1:0] deleg
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> cause == '0); // R10
  AST_DELEG_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    csr_sel == 3'd2 |-> (csr_rdata & ~XLEN'(MASK_DELEG)) == '0); // R2
  AST_MMIO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_we && mm_off != '0) |-> !mm_ack); // R6
  AST_MMIO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_ack && mm_byte[0]) |=> pend[BIT_MSW]); // R6
  AST_MTIMER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend[BIT_MTM] == $past(irq_mtimer)); // R3
  AST_M_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_M && !mie_glb) |-> !take); // R7
  AST_S_DELEG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_S && !sie_glb && take) |-> !deleg[cause]); // R8
endmodule

bind irq_arb irq_arb_checker #(.NIRQ(NIRQ), .XLEN(XLEN), .OFFW(OFFW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .mie_glb(mie_glb), .sie_glb(sie_glb),
  .irq_mtimer(irq_mtimer), .csr_sel(csr_sel), .csr_rdata(csr_rdata),
  .mm_we(mm_we), .mm_off(mm_off), .mm_byte(mm_byte), .mm_ack(mm_ack),
  .take(take), .cause(cause), .pend(pend_w), .deleg(deleg_w)
);

// File: tb/tb_irq_arb.sv
`timescale 1ns/1ps
module tb_irq_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        mie_glb = 1'b0, sie_glb = 1'b0;
  logic        irq_mtimer = 1'b0, irq_mext = 1'b0, irq_sext = 1'b0, irq_cop = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_sel = 3'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mm_we = 1'b0;
  logic [3:0]  mm_off = '0;
  logic [7:0]  mm_byte = '0;
  logic        mm_ack, take;
  logic [3:0]  cause;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_arb dut (.*);

  // behavioural reference state
  logic [15:0] m_pend, m_en, m_deleg, np;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_en <= 0; m_deleg <= 0;
    end else begin
      np = m_pend;
      np[7] = irq_mtimer; np[11] = irq_mext; np[9] = irq_sext; np[12] = irq_cop;
      if (csr_we) begin
        case (csr_sel)
          3'd0: begin np[1] = csr_wdata[1]; np[5] = csr_wdata[5]; end
          3'd3: begin
            if (m_deleg[1]) np[1] = csr_wdata[1];
            if (m_deleg[5]) np[5] = csr_wdata[5];
          end
          3'd1: m_en <= csr_wdata[15:0] & 16'h1AAA;
          3'd4: m_en <= (m_en & ~m_deleg) | (csr_wdata[15:0] & m_deleg & 16'h1AAA);
          3'd2: m_deleg <= csr_wdata[15:0] & 16'h1222;
          default: ;
        endcase
      end
      if (mm_we && mm_off == 0) np[3] = mm_byte[0];
      m_pend <= np;
    end
  end

  function automatic int exp_cause();
    bit m_ok, s_ok;
    logic [15:0] c;
    m_ok = (priv < 2'd3) || (priv == 2'd3 && mie_glb);
    s_ok = (priv < 2'd1) || (priv == 2'd1 && sie_glb);
    c = m_pend & m_en;
    for (int i = 0; i < 16; i++)
      if (c[i] && ((m_deleg[i] && s_ok) || (!m_deleg[i] && m_ok))) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd();
    case (csr_sel)
      3'd0: return {16'd0, m_pend};
      3'd1: return {16'd0, m_en};
      3'd2: return {16'd0, m_deleg};
      3'd3: return {16'd0, m_pend & m_deleg};
      3'd4: return {16'd0, m_en & m_deleg};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ec;
      ec = exp_cause();
      chk("R9 take", {31'd0, take}, {31'd0, ec >= 0});
      chk("R9 cause", {28'd0, cause}, ec >= 0 ? 32'(ec) : 32'd0);
      chk("R5 rdata", csr_rdata, exp_rd());
      chk("R6 ack", {31'd0, mm_ack}, {31'd0, mm_we && mm_off == 0});
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    csr_we = 1; csr_sel = s; csr_wdata = d; step(); csr_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] e, input string tag);
    csr_sel = s; @(negedge clk); chk(tag, csr_rdata, e); step();
  endtask

  task automatic tk(input logic t, input logic [3:0] c, input string tag);
    @(negedge clk);
    chk(tag, {31'd0, take}, {31'd0, t});
    chk(tag, {28'd0, cause}, {28'd0, c});
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset take", {31'd0, take}, 0);
    chk("R1 reset cause", {28'd0, cause}, 0);
    step(); rst_n = 1; step();
    for (int s = 0; s < 5; s++) rd(3'(s), 0, "R1 regs zero");
    tk(0, 0, "R1 idle");

    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, 32'h1222, "R2 deleg mask");
    wr(3'd2, 0);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, 32'h22, "R3 sw pend mask");
    irq_mtimer = 1; step(); rd(3'd0, 32'hA2, "R3 mtimer line");
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, 32'h1AAA, "R4 enable mask");

    priv = 2'd3; mie_glb = 0; tk(0, 0, "R7 M masked");
    mie_glb = 1; tk(1, 1, "R9 lowest wins");
    wr(3'd0, 0); tk(1, 7, "R9 only mtimer");

    wr(3'd2, 32'hFFFF); wr(3'd0, 32'h22);
    tk(1, 7, "R8 deleg blocked at M");
    priv = 2'd1; mie_glb = 0; sie_glb = 0; tk(1, 7, "R7 below M");
    irq_mtimer = 0; step(); tk(0, 0, "R8 S with sie off");
    sie_glb = 1; tk(1, 1, "R8 S with sie on");
    priv = 2'd0; sie_glb = 0; tk(1, 1, "R8 U always");

    rd(3'd3, 32'h22, "R5 sip view");
    wr(3'd2, 32'h2); rd(3'd3, 32'h2, "R5 sip narrowed");
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd0, 32'h22, "R5 sip write delegated only");
    wr(3'd3, 0); rd(3'd0, 32'h20, "R5 sip clear");
    wr(3'd4, 0); rd(3'd1, 32'h1AA8, "R5 sie write"); rd(3'd4, 0, "R5 sie view");
    rd(3'd6, 0, "R5 unmapped");

    mm_we = 1; mm_off = 0; mm_byte = 8'h01;
    @(negedge clk); chk("R6 ack offset 0", {31'd0, mm_ack}, 1); step();
    mm_we = 0; rd(3'd0, 32'h28, "R6 msip set");
    mm_we = 1; mm_off = 4; mm_byte = 8'h00;
    @(negedge clk); chk("R6 reject", {31'd0, mm_ack}, 0); step();
    mm_we = 0; rd(3'd0, 32'h28, "R6 unchanged");
    mm_we = 1; mm_off = 0; mm_byte = 8'hFE; step(); mm_we = 0;
    rd(3'd0, 32'h20, "R6 msip clear");
    priv = 2'd3; mie_glb = 0; tk(0, 0, "R10 none eligible");

    for (int n = 0; n < 3000; n++) begin
      csr_we = ($urandom % 4) == 0;
      csr_sel = 3'($urandom % 6);
      csr_wdata = $urandom;
      mm_we = ($urandom % 6) == 0;
      mm_off = (($urandom % 3) == 0) ? 4'd0 : 4'($urandom);
      mm_byte = 8'($urandom);
      {irq_mtimer, irq_mext, irq_sext, irq_cop} = 4'($urandom);
      case ($urandom % 3) 0: priv = 2'd0; 1: priv = 2'd1; default: priv = 2'd3; endcase
      mie_glb = 1'($urandom); sie_glb = 1'($urandom);
      step();
    end
    csr_we = 0; mm_we = 0;
    step();

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule